// File: doc/BRIEF.md
# Bus-Slave RAM with Cascaded Return Path

This block is a parameterised single-port memory on a Wishbone-style slave port. It holds `2**ADDR_W` words of `DATA_W` bits. It answers every strobe in the same clock with no wait states. A transfer targets the block only while both the cycle and strobe inputs are high. The write-enable input then picks between storing the write data and returning the word at the given address.

The acknowledge and read-data outputs are built to be chained. The block ORs its own acknowledge with an acknowledge coming from an upstream slave. It does the same with read data: its own read data is forced to zero whenever it is not returning a read. This lets several slaves drive one shared return bus in a row, with no central multiplexer.

The array has no reset. Its contents are undefined until a location has been written.

Top module: `chain_ram_slave`

## Requirements
- R1: Each of the `2**ADDR_W` addresses holds its own `DATA_W`-bit word. A read returns the last word written to that address, and writes to other addresses do not disturb it.
- R2: A write is stored only when `cyc_i`, `stb_i` and `we_i` are all high at a rising clock edge. If `cyc_i` or `stb_i` is low, the memory is left unchanged.
- R3: `ack_o` is high in the same cycle as any cycle in which `cyc_i` and `stb_i` are both high. Strobes held on back to back are acknowledged on every cycle with no gap.
- R4: `ack_chain_i` high drives `ack_o` high. When the block is not selected and `ack_chain_i` is low, `ack_o` is low.
- R5: When the block is not selected, or the selected transfer is a write, `dat_o` equals `dat_chain_i` exactly.
- R6: During a selected read, `dat_o` is the bitwise OR of the stored word at `adr_i` and `dat_chain_i`. The word is available in the same cycle as the acknowledge.
- R7: A read in the cycle right after a write, at the same address, returns the newly written word. This makes read-modify-write sequences work.
- R8: Every write replaces all `DATA_W` bits of the addressed word. No partial update is possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on its rising edge |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer strobe for this slave |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Word address |
| dat_i | input | DATA_W | Write data |
| dat_o | output | DATA_W | Read data merged with the chain input |
| ack_o | output | 1 | Acknowledge merged with the chain input |
| ack_chain_i | input | 1 | Acknowledge from an upstream slave |
| dat_chain_i | input | DATA_W | Read data from an upstream slave |

## Verification
The bench builds the block with `ADDR_W = 4` and `DATA_W = 8`, so all sixteen words can be swept in full. It writes every word, reads every word back, and then tries suppressed writes on every address. Read-modify-write is checked on each location. Chain data patterns run over a spread of byte values, which shows the OR merge and the zero forcing bit by bit. Every combination of the select inputs is tried with the chain acknowledge both high and low.

// File: rtl/chain_ram_slave.sv
module chain_ram_slave #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              ack_o,
  input  logic              ack_chain_i,
  input  logic [DATA_W-1:0] dat_chain_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              sel;
  logic              rd_en;
  logic [DATA_W-1:0] own_dat;

  assign sel   = cyc_i & stb_i;
  assign rd_en = sel & ~we_i;

  always_ff @(posedge clk_i)
    if (sel && we_i) mem[adr_i] <= dat_i;

  assign own_dat = rd_en ? mem[adr_i] : '0;
  assign dat_o   = own_dat | dat_chain_i;
  assign ack_o   = sel | ack_chain_i;
endmodule

// File: rtl/chain_ram_slave_chk.sv
module chain_ram_slave_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              cyc_i,
  input logic              stb_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] adr_i,
  input logic [DATA_W-1:0] dat_i,
  input logic [DATA_W-1:0] dat_o,
  input logic              ack_o,
  input logic              ack_chain_i,
  input logic [DATA_W-1:0] dat_chain_i
);
  logic              wr_seen = 1'b0;
  logic [ADDR_W-1:0] wr_adr  = '0;
  logic [DATA_W-1:0] wr_dat  = '0;

  always_ff @(posedge clk_i) begin
    wr_seen <= cyc_i & stb_i & we_i;
    wr_adr  <= adr_i;
    wr_dat  <= dat_i;
  end

  always @(negedge clk_i) begin
    if (cyc_i && stb_i)
      AST_ACK_ON_SEL: assert (ack_o); // R3
    if (ack_chain_i)
      AST_ACK_CHAIN: assert (ack_o); // R4
    if (!(cyc_i && stb_i) && !ack_chain_i)
      AST_ACK_QUIET: assert (!ack_o); // R4
    if (!(cyc_i && stb_i) || we_i)
      AST_DAT_PASS: assert (dat_o == dat_chain_i); // R5
    AST_DAT_COVERS_CHAIN: assert ((dat_o & dat_chain_i) == dat_chain_i); // R6
    if (wr_seen && cyc_i && stb_i && !we_i && adr_i == wr_adr)
      AST_READ_AFTER_WRITE: assert (dat_o == (wr_dat | dat_chain_i)); // R7
  end
endmodule

bind chain_ram_slave chain_ram_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_chain_ram_slave.sv
module sim_chain_ram_slave;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0, ackc = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] din = '0, datc = '0;
  logic [DW-1:0] dout;
  logic ack;
  logic [DW-1:0] model [N];
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  chain_ram_slave #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(din), .dat_o(dout), .ack_o(ack),
    .ack_chain_i(ackc), .dat_chain_i(datc));

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'((a * 37 + s * 11 + 5) & ((1 << DW) - 1));
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic c, input logic s, input logic w, input int a,
                      input logic [DW-1:0] d, input logic ac, input logic [DW-1:0] dc,
                      input string req);
    logic sel;
    logic [DW-1:0] exp_d;
    @(posedge clk); #1;
    cyc = c; stb = s; we = w; adr = AW'(a); din = d; ackc = ac; datc = dc;
    sel = c & s;
    @(negedge clk);
    chk({req, " ack"}, DW'(ack), DW'(sel | ac));
    exp_d = (sel && !w) ? (model[a] | dc) : dc;
    chk({req, " dat"}, dout, exp_d);
    if (sel && w) model[a] = d;
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R4 idle ack", DW'(ack), '0);
    chk("R5 idle dat", dout, '0);
    // R1 R3 R8: fill every word with a back-to-back write burst
    for (int a = 0; a < N; a++) xfer(1, 1, 1, a, pat(a, 0), 0, '0, "R1 R3 R8 write");
    // R1 R6: read burst with no chain data
    for (int a = 0; a < N; a++) xfer(1, 1, 0, a, '0, 0, '0, "R1 R6 read");
    // R2: suppressed writes with cyc or stb low
    for (int a = 0; a < N; a++) begin
      xfer(0, 1, 1, a, ~pat(a, 0), 0, DW'(a), "R2 cyc low");
      xfer(1, 0, 1, a, ~pat(a, 0), 1, '0, "R2 stb low");
    end
    for (int a = 0; a < N; a++) xfer(1, 1, 0, a, '0, 0, '0, "R2 readback");
    // R6 R5: chain data merged on reads, passed through on writes
    for (int a = 0; a < N; a++) xfer(1, 1, 0, a, '0, a[0], pat(a, 3), "R6 merge");
    for (int a = 0; a < N; a++) xfer(1, 1, 1, a, pat(a, 5), 1, pat(a, 7), "R5 write pass");
    // R7 R8: read-modify-write on every word
    for (int a = 0; a < N; a++) begin
      xfer(1, 1, 0, a, '0, 0, '0, "R7 rmw read");
      xfer(1, 1, 1, a, ~model[a], 0, '0, "R7 R8 rmw write");
      xfer(1, 1, 0, a, '0, 0, '0, "R7 rmw readback");
    end
    // R4: every select combination against the chain acknowledge
    for (int k = 0; k < 16; k++)
      xfer(k[0], k[1], 0, k, '0, k[2], k[3] ? 8'hA5 : 8'h00, "R4 combo");
    // R1: final sweep after everything
    for (int a = 0; a < N; a++) xfer(1, 1, 0, a, '0, 0, '0, "R1 final");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule